// File: doc/BRIEF.md
# Bit-Band Alias Bridge

The bridge is a memory-mapped slave that fronts a 32 MiB alias window. Every 32-bit word of the window stands for one bit of a 1 MiB target region. Eight alias words, spaced four bytes apart, cover one target byte. The bridge turns each alias access into an access on its master port.

An alias read fetches the target unit at the requested size and returns the selected bit as 0 or 1. An alias write is a locked read-modify-write. The bridge reads the unit, changes only the selected bit and writes the unit back. No other master access can come between that read and that write.

Two copies are normally placed. One serves the SRAM region, with alias base 0x2200_0000 and target base 0x2000_0000. The other serves the peripheral region, with alias base 0x4200_0000 and target base 0x4000_0000. The slave port receives the offset inside the alias window. The target base is a parameter and must be 1 MiB aligned.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is held and after it is released, `s_ready_o`, `m_req_o` and `s_rdata_o` are all zero until a request arrives.
- R2: The master address is the target base OR'd with alias offset bits [24:5]. Size code 1 (halfword) clears address bit 0. Size code 2 (word) clears address bits [1:0]. Size code 0 (byte) keeps every bit. Offset bits [1:0] play no part.
- R3: The selected bit index is offset bits [4:2] for a byte, offset bits [5:2] for a halfword and offset bits [6:2] for a word. Index 0 is the least significant bit of the unit.
- R4: A read issues exactly one master read and no master write. It returns the selected bit in `s_rdata_o[0]` with bits [31:1] zero.
- R5: A write issues one master read and then one master write. Both go to the same address and size, with no other master access between them. The written unit equals the read unit with only the selected bit changed, and that bit takes the value of write-data bit 0. The acknowledge of a write returns zero data.
- R6: Write-data bits [31:1] have no effect on the target.
- R7: Once `m_req_o` is raised, it stays high with its address, size, direction and data unchanged until `m_ready_i` is seen.
- R8: `s_ready_o` is a one-cycle pulse and is never high while a master access is outstanding. A slave request held high while the bridge is busy is served, not dropped.
- R9: With L wait cycles per master access, a read is acknowledged L+2 cycles after the request is presented and a write 2L+4 cycles after.
- R10: `m_size_o` equals the requested size. A unit is little-endian and right-justified on the master data bus, with the byte at the lowest address in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_req_i | input | 1 | Slave request; held with its fields stable until `s_ready_o` |
| s_we_i | input | 1 | Slave write (1) or read (0) |
| s_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| s_off_i | input | ALIAS_AW | Byte offset inside the alias window |
| s_wdata_i | input | DW | Write data; only bit 0 is used |
| s_ready_o | output | 1 | One-cycle acknowledge; `s_rdata_o` is valid with it |
| s_rdata_o | output | DW | Read result (selected bit in bit 0) |
| m_req_o | output | 1 | Master request |
| m_we_o | output | 1 | Master write (1) or read (0) |
| m_size_o | output | 2 | Master access size, same code as `s_size_i` |
| m_addr_o | output | AW | Target byte address |
| m_wdata_o | output | DW | Master write data, right-justified unit |
| m_ready_i | input | 1 | Master handshake; the access completes on a cycle with `m_req_o` and `m_ready_i` both high |
| m_rdata_i | input | DW | Master read data, valid with `m_ready_i` |

## Verification
A read result appears on `s_ready_o`/`s_rdata_o` in the cycle after the master read handshake. A write-back is issued two cycles after the read handshake, and the write acknowledge follows the write-back handshake by one cycle. That gives L+2 and 2L+4 cycles from the request for L wait cycles.

The bench changes L between 0 and 2 on each access. It counts the falling edges from the moment it presents a request to the moment `s_ready_o` is seen, and compares that count with the formula. The acknowledge data is sampled on that same falling edge, and the next falling edge confirms that the pulse has ended.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE
  } state_e;

  // Bits of a right-justified unit that carry data for a given size.
  function automatic logic [31:0] unit_mask(size_e sz);
    case (sz)
      SZ_BYTE: unit_mask = 32'h0000_00ff;
      SZ_HALF: unit_mask = 32'h0000_ffff;
      default: unit_mask = 32'hffff_ffff;
    endcase
  endfunction

endpackage

// File: rtl/bitband_addr_map.sv
module bitband_addr_map import bitband_pkg::*; #(
  parameter int              ALIAS_AW = 25,
  parameter int              AW       = 32,
  parameter int              IDX_W    = 5,
  parameter logic [AW-1:0]   TGT_BASE = 32'h2000_0000
) (
  input  logic [ALIAS_AW-1:0] off_i,
  input  size_e               size_i,
  output logic [AW-1:0]       addr_o,
  output logic [IDX_W-1:0]    idx_o
);
  // 4 alias bytes per bit, 8 bits per target byte
  localparam int SHIFT = 5;

  logic [AW-1:0]    raw_addr;
  logic [IDX_W-1:0] raw_idx;
  logic             unused_lsb;

  assign raw_addr   = TGT_BASE | AW'(off_i[ALIAS_AW-1:SHIFT]);
  assign raw_idx    = off_i[IDX_W+1:2];
  assign unused_lsb = ^off_i[1:0];

  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        addr_o = raw_addr;
        idx_o  = raw_idx & IDX_W'(7);
      end
      SZ_HALF: begin
        addr_o = {raw_addr[AW-1:1], 1'b0};
        idx_o  = raw_idx & IDX_W'(15);
      end
      default: begin
        addr_o = {raw_addr[AW-1:2], 2'b00};
        idx_o  = raw_idx;
      end
    endcase
  end

endmodule

// File: rtl/bitband_bit_ops.sv
module bitband_bit_ops #(
  parameter int DW    = 32,
  parameter int IDX_W = $clog2(DW)
) (
  input  logic [DW-1:0]    unit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             val_i,
  output logic             bit_o,
  output logic [DW-1:0]    merged_o
);
  logic [DW-1:0] sel;

  assign sel      = DW'(1) << idx_i;
  assign bit_o    = unit_i[idx_i];
  assign merged_o = val_i ? (unit_i | sel) : (unit_i & ~sel);

endmodule

// File: rtl/bitband_rmw_ctrl.sv
module bitband_rmw_ctrl import bitband_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_req_i,
  input  logic             s_we_i,
  input  size_e            size_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             val_i,
  input  logic             m_ready_i,
  input  logic [DW-1:0]    rd_unit_i,
  input  logic             bit_i,
  input  logic [DW-1:0]    merged_i,
  output state_e           st_o,
  output logic [DW-1:0]    unit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             val_o,
  output size_e            size_o,
  output logic [AW-1:0]    addr_o,
  output logic             m_req_o,
  output logic             m_we_o,
  output logic             s_ready_o,
  output logic [DW-1:0]    s_rdata_o
);
  state_e           st_q;
  logic             we_q, val_q, ready_q;
  size_e            size_q;
  logic [AW-1:0]    addr_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    unit_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      we_q    <= 1'b0;
      val_q   <= 1'b0;
      ready_q <= 1'b0;
      size_q  <= SZ_BYTE;
      addr_q  <= '0;
      idx_q   <= '0;
      unit_q  <= '0;
      rdata_q <= '0;
    end else begin
      ready_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          // ready_q high: requester has not yet dropped the served request
          if (s_req_i && !ready_q) begin
            we_q   <= s_we_i;
            val_q  <= val_i;
            size_q <= size_i;
            addr_q <= addr_i;
            idx_q  <= idx_i;
            st_q   <= ST_READ;
          end
        end
        ST_READ: begin
          if (m_ready_i) begin
            if (we_q) begin
              unit_q <= rd_unit_i;
              st_q   <= ST_MODIFY;
            end else begin
              rdata_q <= DW'(bit_i);
              ready_q <= 1'b1;
              st_q    <= ST_IDLE;
            end
          end
        end
        ST_MODIFY: begin
          unit_q <= merged_i;
          st_q   <= ST_WRITE;
        end
        ST_WRITE: begin
          if (m_ready_i) begin
            rdata_q <= '0;
            ready_q <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o      = st_q;
  assign unit_o    = unit_q;
  assign idx_o     = idx_q;
  assign val_o     = val_q;
  assign size_o    = size_q;
  assign addr_o    = addr_q;
  assign m_req_o   = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign m_we_o    = (st_q == ST_WRITE);
  assign s_ready_o = ready_q;
  assign s_rdata_o = rdata_q;

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge import bitband_pkg::*; #(
  parameter int            ALIAS_AW = 25,
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] TGT_BASE = 32'h2000_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s_req_i,
  input  logic                s_we_i,
  input  logic [1:0]          s_size_i,
  input  logic [ALIAS_AW-1:0] s_off_i,
  input  logic [DW-1:0]       s_wdata_i,
  output logic                s_ready_o,
  output logic [DW-1:0]       s_rdata_o,
  output logic                m_req_o,
  output logic                m_we_o,
  output logic [1:0]          m_size_o,
  output logic [AW-1:0]       m_addr_o,
  output logic [DW-1:0]       m_wdata_o,
  input  logic                m_ready_i,
  input  logic [DW-1:0]       m_rdata_i
);
  localparam int IDX_W = $clog2(DW);

  logic [AW-1:0]    map_addr;
  logic [IDX_W-1:0] map_idx, idx_q;
  state_e           st;
  size_e            size_q;
  logic [DW-1:0]    unit_q, rd_unit, ops_unit, merged;
  logic             ops_bit, val_q;
  logic             unused_wdata;

  assign unused_wdata = ^s_wdata_i[DW-1:1];

  bitband_addr_map #(
    .ALIAS_AW (ALIAS_AW),
    .AW       (AW),
    .IDX_W    (IDX_W),
    .TGT_BASE (TGT_BASE)
  ) i_addr_map (
    .off_i  (s_off_i),
    .size_i (size_e'(s_size_i)),
    .addr_o (map_addr),
    .idx_o  (map_idx)
  );

  assign rd_unit  = m_rdata_i & DW'(unit_mask(size_q));
  // Extract from the live read data; merge from the captured unit.
  assign ops_unit = (st == ST_READ) ? rd_unit : unit_q;

  bitband_bit_ops #(
    .DW    (DW),
    .IDX_W (IDX_W)
  ) i_bit_ops (
    .unit_i   (ops_unit),
    .idx_i    (idx_q),
    .val_i    (val_q),
    .bit_o    (ops_bit),
    .merged_o (merged)
  );

  bitband_rmw_ctrl #(
    .AW    (AW),
    .DW    (DW),
    .IDX_W (IDX_W)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_req_i   (s_req_i),
    .s_we_i    (s_we_i),
    .size_i    (size_e'(s_size_i)),
    .addr_i    (map_addr),
    .idx_i     (map_idx),
    .val_i     (s_wdata_i[0]),
    .m_ready_i (m_ready_i),
    .rd_unit_i (rd_unit),
    .bit_i     (ops_bit),
    .merged_i  (merged),
    .st_o      (st),
    .unit_o    (unit_q),
    .idx_o     (idx_q),
    .val_o     (val_q),
    .size_o    (size_q),
    .addr_o    (m_addr_o),
    .m_req_o   (m_req_o),
    .m_we_o    (m_we_o),
    .s_ready_o (s_ready_o),
    .s_rdata_o (s_rdata_o)
  );

  assign m_size_o  = size_q;
  assign m_wdata_o = unit_q;

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk import bitband_pkg::*; #(
  parameter int            ALIAS_AW = 25,
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] TGT_BASE = 32'h2000_0000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          s_ready_o,
  input logic [DW-1:0] s_rdata_o,
  input logic          m_req_o,
  input logic          m_we_o,
  input logic [1:0]    m_size_o,
  input logic [AW-1:0] m_addr_o,
  input logic [DW-1:0] m_wdata_o,
  input logic          m_ready_i,
  input logic [DW-1:0] m_rdata_i
);
  localparam int LO = ALIAS_AW - 5;

  logic [AW-1:0] last_rd_addr;
  logic [DW-1:0] last_rd_unit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_rd_addr <= '0;
      last_rd_unit <= '0;
    end else if (m_req_o && m_ready_i && !m_we_o) begin
      last_rd_addr <= m_addr_o;
      last_rd_unit <= m_rdata_i & DW'(unit_mask(size_e'(m_size_o)));
    end
  end

  AST_BASE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> m_addr_o[AW-1:LO] == TGT_BASE[AW-1:LO]);  // R2
  AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && m_size_o == 2'd2) |-> m_addr_o[1:0] == 2'b00);  // R2
  AST_HALF_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && m_size_o == 2'd1) |-> !m_addr_o[0]);  // R2
  AST_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (s_rdata_o >> 1) == '0);  // R4
  AST_WB_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && m_we_o) |-> m_addr_o == last_rd_addr);  // R5
  AST_WB_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && m_we_o) |-> $countones(m_wdata_o ^ last_rd_unit) <= 1);  // R5
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && !m_ready_i) |=> (m_req_o && $stable(m_addr_o) && $stable(m_we_o)
                                 && $stable(m_size_o) && $stable(m_wdata_o)));  // R7
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |=> !s_ready_o);  // R8
  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> !s_ready_o);  // R8

endmodule

bind bitband_bridge bitband_bridge_chk #(
  .ALIAS_AW (ALIAS_AW),
  .AW       (AW),
  .DW       (DW),
  .TGT_BASE (TGT_BASE)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .s_ready_o (s_ready_o),
  .s_rdata_o (s_rdata_o),
  .m_req_o   (m_req_o),
  .m_we_o    (m_we_o),
  .m_size_o  (m_size_o),
  .m_addr_o  (m_addr_o),
  .m_wdata_o (m_wdata_o),
  .m_ready_i (m_ready_i),
  .m_rdata_i (m_rdata_i)
);

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;
  localparam int            CLK_P    = 10;
  localparam int            ALIAS_AW = 25;
  localparam int            AW       = 32;
  localparam int            DW       = 32;
  localparam logic [31:0]   TGT_BASE = 32'h2000_0000;
  localparam int            NBYTES   = 256;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                s_req_i = 1'b0, s_we_i = 1'b0;
  logic [1:0]          s_size_i = 2'd0;
  logic [ALIAS_AW-1:0] s_off_i = '0;
  logic [DW-1:0]       s_wdata_i = '0;
  logic                s_ready_o;
  logic [DW-1:0]       s_rdata_o;
  logic                m_req_o, m_we_o, m_ready_i;
  logic [1:0]          m_size_o;
  logic [AW-1:0]       m_addr_o;
  logic [DW-1:0]       m_wdata_o, m_rdata_i;

  int n_chk = 0, n_bad = 0;
  int lat = 0, wcnt = 0;
  int rd_tot = 0, wr_tot = 0, op_tot = 0, rd_seq = 0, wr_seq = 0;
  logic [AW-1:0] rd_addr_l, wr_addr_l;
  logic [1:0]    rd_size_l, wr_size_l;
  logic [DW-1:0] wr_data_l;
  logic [7:0] mem [NBYTES];
  logic [7:0] ref_mem [NBYTES];

  always #(CLK_P/2) clk_i = ~clk_i;

  bitband_bridge #(
    .ALIAS_AW (ALIAS_AW), .AW (AW), .DW (DW), .TGT_BASE (TGT_BASE)
  ) i_bitband_bridge (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .s_req_i (s_req_i), .s_we_i (s_we_i), .s_size_i (s_size_i),
    .s_off_i (s_off_i), .s_wdata_i (s_wdata_i),
    .s_ready_o (s_ready_o), .s_rdata_o (s_rdata_o),
    .m_req_o (m_req_o), .m_we_o (m_we_o), .m_size_o (m_size_o),
    .m_addr_o (m_addr_o), .m_wdata_o (m_wdata_o),
    .m_ready_i (m_ready_i), .m_rdata_i (m_rdata_i)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // memory model: little-endian, right-justified unit, L wait cycles
  assign m_ready_i = m_req_o && (wcnt >= lat);

  always_comb begin
    logic [7:0] a;
    a = m_addr_o[7:0];
    case (m_size_o)
      2'd0:    m_rdata_i = {24'h0, mem[a]};
      2'd1:    m_rdata_i = {16'h0, mem[8'(a+1)], mem[a]};
      default: m_rdata_i = {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a]};
    endcase
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= pat(i);
      wcnt <= 0;
    end else if (m_req_o && m_ready_i) begin
      wcnt   <= 0;
      op_tot <= op_tot + 1;
      if (m_we_o) begin
        wr_tot <= wr_tot + 1; wr_seq <= op_tot + 1;
        wr_addr_l <= m_addr_o; wr_size_l <= m_size_o; wr_data_l <= m_wdata_o;
        mem[m_addr_o[7:0]] <= m_wdata_o[7:0];
        if (m_size_o != 2'd0) mem[8'(m_addr_o[7:0]+1)] <= m_wdata_o[15:8];
        if (m_size_o == 2'd2) begin
          mem[8'(m_addr_o[7:0]+2)] <= m_wdata_o[23:16];
          mem[8'(m_addr_o[7:0]+3)] <= m_wdata_o[31:24];
        end
      end else begin
        rd_tot <= rd_tot + 1; rd_seq <= op_tot + 1;
        rd_addr_l <= m_addr_o; rd_size_l <= m_size_o;
      end
    end else if (m_req_o) begin
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_unit(logic [31:0] a, int sz);
    logic [7:0] b;
    b = a[7:0];
    case (sz)
      0:       return {24'h0, ref_mem[b]};
      1:       return {16'h0, ref_mem[8'(b+1)], ref_mem[b]};
      default: return {ref_mem[8'(b+3)], ref_mem[8'(b+2)], ref_mem[8'(b+1)], ref_mem[b]};
    endcase
  endfunction

  task automatic access(input bit we, input int sz, input int off, input logic [31:0] wd, input int l);
    int rd0, wr0, cyc, idx;
    logic [31:0] ea, u, nu, got;
    rd0 = rd_tot; wr0 = wr_tot;
    ea  = TGT_BASE | 32'(off >> 5);
    if (sz == 1) ea[0] = 1'b0;
    if (sz == 2) ea[1:0] = 2'b00;
    idx = (off >> 2) & ((sz == 0) ? 7 : (sz == 1) ? 15 : 31);
    @(negedge clk_i);
    lat = l;
    s_req_i = 1'b1; s_we_i = we; s_size_i = 2'(sz);
    s_off_i = ALIAS_AW'(off); s_wdata_i = wd;
    cyc = 0;
    do begin
      @(negedge clk_i); cyc++;
    end while (!s_ready_o && cyc < 100);
    got = s_rdata_o;
    s_req_i = 1'b0;
    chk(s_ready_o, "R8 request served", 32'(s_ready_o), 32'd1);
    chk(cyc == (we ? 2*l + 4 : l + 2), "R9 ack latency", 32'(cyc), 32'(we ? 2*l + 4 : l + 2));
    chk(rd_tot - rd0 == 1, "R4/R5 master reads", 32'(rd_tot - rd0), 32'd1);
    chk(wr_tot - wr0 == (we ? 1 : 0), "R4/R5 master writes", 32'(wr_tot - wr0), 32'(we));
    chk(rd_addr_l == ea, "R2 target address", rd_addr_l, ea);
    chk(rd_size_l == 2'(sz), "R10 master size", 32'(rd_size_l), 32'(sz));
    u = ref_unit(ea, sz);
    if (!we) begin
      chk(got == 32'(u[idx]), "R3/R4 read bit", got, 32'(u[idx]));
    end else begin
      nu = u;
      nu[idx] = wd[0];
      for (int i = 0; i < (1 << sz); i++) ref_mem[8'(ea[7:0] + 8'(i))] = nu[8*i +: 8];
      chk(got == 32'h0, "R5 write ack data", got, 32'h0);
      chk(wr_addr_l == ea && wr_size_l == 2'(sz), "R5 write-back address", wr_addr_l, ea);
      chk(wr_data_l == nu, "R5/R6 write-back unit", wr_data_l, nu);
      chk(wr_seq == rd_seq + 1, "R5 locked sequence", 32'(wr_seq), 32'(rd_seq + 1));
    end
    @(negedge clk_i);
    chk(!s_ready_o, "R8 ack is one pulse", 32'(s_ready_o), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NBYTES; i++) ref_mem[i] = pat(i);
    repeat (3) @(negedge clk_i);
    chk(!s_ready_o && !m_req_o && s_rdata_o == '0, "R1 reset state",
        {30'h0, s_ready_o, m_req_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!s_ready_o && !m_req_o && s_rdata_o == '0, "R1 after reset",
        {30'h0, s_ready_o, m_req_o}, 32'h0);

    // read sweep over every bit of target bytes 0..63 at all sizes
    for (int sz = 0; sz < 3; sz++)
      for (int k = 0; k < 512; k++)
        access(1'b0, sz, k*4 + (k % 4), 32'h0, (k + sz) % 3);

    // write sweep with noisy upper data bits (R6)
    for (int k = 0; k < 512; k++)
      access(1'b1, k % 3, ((k * 28) + (k % 4)) & 2047,
             {31'(k * 32'h9e37_79b9), 1'(((k >> 1) ^ k) & 1)}, k % 3);

    // R6: all-ones upper bits with bit 0 clear must clear the bit
    access(1'b1, 0, 12, 32'hffff_fffe, 1);
    access(1'b0, 0, 12, 32'h0, 0);
    access(1'b1, 2, 64*32 + 31*4, 32'h8000_0001, 2);
    access(1'b0, 2, 64*32 + 31*4, 32'h0, 2);

    // read back all bits after the writes
    for (int k = 0; k < 520; k++) access(1'b0, 0, k*4, 32'h0, k % 2);

    for (int i = 0; i < NBYTES; i++)
      if (mem[i] != ref_mem[i]) chk(1'b0, "R5 target contents", 32'(mem[i]), 32'(ref_mem[i]));
    chk(1'b1, "R5 target contents", 32'h0, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule